// File: doc/BRIEF.md
# Paged Register Address Translator

This block turns the register operand of an 8-bit microcontroller instruction into a 12-bit physical address in a 4 KB paged register file. A single pointer byte steers the mapping. Its upper nibble picks the current working group of sixteen registers, and its lower nibble picks one of sixteen pages of 256 bytes. A short operand names one of the sixteen working registers. A full 8-bit operand names an in-page byte directly. The exception is an 8-bit operand whose upper nibble is 1110b: it is folded back onto the working group.

Besides the address, the block reports two things. It marks a target that falls in the core control area, which is the top sixteen bytes of page 0. It also raises an error for the undefined pointer value (group 1110b on page 0) and for an odd-numbered register-pair operand. The result may be registered so that the translation fits a pipelined decode stage. The register file storage and the control registers themselves sit outside this block.

Top module: `rat_translator`

## Requirements
- R1: With `wide_i`=0, `addr_o` = {ptr_i[3:0], ptr_i[7:4], opnd_i[3:0]}, so the page, the group and the register are concatenated from most to least significant.
- R2: With `wide_i`=1 and opnd_i[7:4] other than 4'hE, `addr_o` = {ptr_i[3:0], opnd_i}.
- R3: With `wide_i`=1 and opnd_i[7:4] = 4'hE, `addr_o` = {ptr_i[3:0], ptr_i[7:4], opnd_i[3:0]}, the same as a working-register reference.
- R4: `ctrl_o` is 1 exactly when ptr_i[3:0] = 0 and the resolved in-page address (addr_o[7:0]) lies in F0h–FFh.
- R5: `err_o` is 1 whenever ptr_i = 8'hE0, whatever the operand.
- R6: With `pair_i`=1 and a resolved in-page address that is odd, `err_o` is 1 and addr_o[0] is forced to 0. An even pair address passes unchanged and raises no error from this rule.
- R7: With REG_OUT=1 the outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, the outputs become all zero.
- R8: With `wide_i`=0, opnd_i[7:4] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| ptr_i | input | 8 | Pointer byte: [7:4] working group, [3:0] page |
| wide_i | input | 1 | 1 = 8-bit register operand, 0 = 4-bit working-register operand |
| opnd_i | input | 8 | Operand field; only [3:0] is used when wide_i=0 |
| pair_i | input | 1 | Operand names a register pair (must be even) |
| addr_o | output | 12 | Physical register-file address |
| ctrl_o | output | 1 | Target is a core control register |
| err_o | output | 1 | Undefined pointer or odd pair operand |

## Verification
On every cycle the assertions check several things: the page prefix of the address, that the control flag appears only on page 0 in the top sixteen bytes, that the undefined pointer always sets the error, that pair addresses come out even, and that the registered outputs follow the combinational result one cycle later and are cleared by reset. Only the bench's scenarios can show that the full mapping is right for every pointer against every 4-bit and 8-bit operand. The same holds for window redirection on page 0 versus other pages, for the upper nibble of a short operand being ignored, and for each hand-picked corner in the vector table.

// File: rtl/rat_pkg.sv
package rat_pkg;
  // How an operand field is interpreted after decode
  typedef enum logic [1:0] {
    K_WORK   = 2'd0,  // short working-register number
    K_DIRECT = 2'd1,  // full in-page address
    K_WINDOW = 2'd2   // full operand inside the working-group window
  } opnd_kind_e;
endpackage

// File: rtl/rat_ptr_split.sv
module rat_ptr_split #(
  parameter int GRP_W  = 4,
  parameter int PAGE_W = 4
) (
  input  logic [GRP_W+PAGE_W-1:0] ptr_i,
  output logic [GRP_W-1:0]        grp_o,
  output logic [PAGE_W-1:0]       page_o,
  output logic                    bad_o
);
  localparam logic [GRP_W-1:0] WIN_TAG = {{(GRP_W-1){1'b1}}, 1'b0};

  assign grp_o  = ptr_i[GRP_W+PAGE_W-1:PAGE_W];
  assign page_o = ptr_i[PAGE_W-1:0];
  // the window group cannot be the working group on page 0
  assign bad_o  = (grp_o == WIN_TAG) && (page_o == '0);
endmodule

// File: rtl/rat_resolve.sv
module rat_resolve
  import rat_pkg::*;
#(
  parameter int GRP_W = 4,
  parameter int REG_W = 4
) (
  input  logic [GRP_W-1:0]       grp_i,
  input  logic                   wide_i,
  input  logic [GRP_W+REG_W-1:0] opnd_i,
  input  logic                   pair_i,
  output logic [GRP_W+REG_W-1:0] inpage_o,
  output logic                   odd_o
);
  localparam int OP_W = GRP_W + REG_W;
  localparam logic [GRP_W-1:0] WIN_TAG = {{(GRP_W-1){1'b1}}, 1'b0};

  logic [GRP_W-1:0] hi;
  logic [REG_W-1:0] lo;
  logic [OP_W-1:0]  raw;
  opnd_kind_e       kind;

  assign hi = opnd_i[OP_W-1:REG_W];
  assign lo = opnd_i[REG_W-1:0];

  always_comb begin
    if (!wide_i)             kind = K_WORK;
    else if (hi == WIN_TAG)  kind = K_WINDOW;
    else                     kind = K_DIRECT;
  end

  always_comb begin
    unique case (kind)
      K_DIRECT: raw = opnd_i;
      default:  raw = {grp_i, lo};
    endcase
  end

  assign odd_o    = pair_i & raw[0];
  assign inpage_o = {raw[OP_W-1:1], raw[0] & ~pair_i};
endmodule

// File: rtl/rat_classify.sv
module rat_classify #(
  parameter int PAGE_W = 4,
  parameter int HI_W   = 4
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [HI_W-1:0]   inpage_hi_i,
  output logic              ctrl_o
);
  // core control area: top row of page 0
  assign ctrl_o = (page_i == '0) && (&inpage_hi_i);
endmodule

// File: rtl/rat_translator.sv
module rat_translator #(
  parameter int PAGE_W  = 4,
  parameter int GRP_W   = 4,
  parameter int REG_W   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [GRP_W+PAGE_W-1:0]       ptr_i,
  input  logic                          wide_i,
  input  logic [GRP_W+REG_W-1:0]        opnd_i,
  input  logic                          pair_i,
  output logic [PAGE_W+GRP_W+REG_W-1:0] addr_o,
  output logic                          ctrl_o,
  output logic                          err_o
);
  localparam int OP_W   = GRP_W + REG_W;
  localparam int ADDR_W = PAGE_W + OP_W;

  logic [GRP_W-1:0]  grp;
  logic [PAGE_W-1:0] page;
  logic              bad_ptr;
  logic [OP_W-1:0]   inpage;
  logic              odd_pair;
  logic              ctrl_c;
  logic [ADDR_W-1:0] addr_c;
  logic              err_c;

  rat_ptr_split #(.GRP_W(GRP_W), .PAGE_W(PAGE_W)) split_i (
    .ptr_i (ptr_i),
    .grp_o (grp),
    .page_o(page),
    .bad_o (bad_ptr)
  );

  rat_resolve #(.GRP_W(GRP_W), .REG_W(REG_W)) resolve_i (
    .grp_i   (grp),
    .wide_i  (wide_i),
    .opnd_i  (opnd_i),
    .pair_i  (pair_i),
    .inpage_o(inpage),
    .odd_o   (odd_pair)
  );

  rat_classify #(.PAGE_W(PAGE_W), .HI_W(GRP_W)) classify_i (
    .page_i     (page),
    .inpage_hi_i(inpage[OP_W-1:REG_W]),
    .ctrl_o     (ctrl_c)
  );

  assign addr_c = {page, inpage};
  assign err_c  = bad_ptr | odd_pair;

  // R1/R2/R3: page always leads the physical address
  a_r1_page_prefix: assert property (@(posedge clk) disable iff (rst)
    addr_c[ADDR_W-1:OP_W] == ptr_i[PAGE_W-1:0]);
  // R4: control flag only in the top row of page 0
  a_r4_ctrl_page0: assert property (@(posedge clk) disable iff (rst)
    ctrl_c |-> (ptr_i[PAGE_W-1:0] == '0) && (&addr_c[OP_W-1:REG_W]));
  // R5: undefined pointer always reported
  a_r5_bad_ptr_err: assert property (@(posedge clk) disable iff (rst)
    (ptr_i == {{(GRP_W-1){1'b1}}, 1'b0, {PAGE_W{1'b0}}}) |-> err_c);
  // R6: pair addresses are even
  a_r6_pair_even: assert property (@(posedge clk) disable iff (rst)
    pair_i |-> !addr_c[0]);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          addr_o <= '0;
          ctrl_o <= 1'b0;
          err_o  <= 1'b0;
        end else begin
          addr_o <= addr_c;
          ctrl_o <= ctrl_c;
          err_o  <= err_c;
        end
      end

      // R7: reset clears the outputs
      a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (addr_o == '0) && !ctrl_o && !err_o);
      // R7: one-cycle latency
      a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (addr_o == $past(addr_c)) && (ctrl_o == $past(ctrl_c))
                        && (err_o == $past(err_c)));
    end else begin : g_comb
      assign addr_o = addr_c;
      assign ctrl_o = ctrl_c;
      assign err_o  = err_c;
    end
  endgenerate
endmodule

// File: tb/rat_translator_tb.sv
module rat_translator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 13;

  // vector: {ptr[31:24], wide[23], opnd[22:15], pair[14], addr[13:2], ctrl[1], err[0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 1'b1, 8'h43, 1'b0, 12'h043, 1'b0, 1'b0},
    {8'h00, 1'b1, 8'hE8, 1'b0, 12'h008, 1'b0, 1'b0},
    {8'h70, 1'b0, 8'h05, 1'b0, 12'h075, 1'b0, 1'b0},
    {8'h00, 1'b1, 8'hFD, 1'b0, 12'h0FD, 1'b1, 1'b0},
    {8'h03, 1'b1, 8'hFD, 1'b0, 12'h3FD, 1'b0, 1'b0},
    {8'hF0, 1'b0, 8'h0C, 1'b0, 12'h0FC, 1'b1, 1'b0},
    {8'hE0, 1'b1, 8'h10, 1'b0, 12'h010, 1'b0, 1'b1},
    {8'h21, 1'b0, 8'h03, 1'b1, 12'h122, 1'b0, 1'b1},
    {8'h21, 1'b0, 8'h06, 1'b1, 12'h126, 1'b0, 1'b0},
    {8'h5A, 1'b0, 8'hB7, 1'b0, 12'hA57, 1'b0, 1'b0},
    {8'hC2, 1'b1, 8'hEF, 1'b0, 12'h2CF, 1'b0, 1'b0},
    {8'h0E, 1'b1, 8'hE3, 1'b0, 12'hE03, 1'b0, 1'b0},
    {8'hE0, 1'b0, 8'h0F, 1'b0, 12'h0EF, 1'b0, 1'b1}
  };
  localparam string VTAG [NVEC] = '{
    "R2", "R3", "R1", "R4", "R4", "R4", "R5", "R6", "R6", "R8", "R3", "R3", "R5"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ptr_i = '0;
  logic        wide_i = 1'b0;
  logic [7:0]  opnd_i = '0;
  logic        pair_i = 1'b0;
  logic [11:0] addr_o;
  logic        ctrl_o;
  logic        err_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit          pend = 0;
  logic [13:0] pend_exp;
  string       pend_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  rat_translator dut_i (
    .clk(clk), .rst(rst), .ptr_i(ptr_i), .wide_i(wide_i),
    .opnd_i(opnd_i), .pair_i(pair_i),
    .addr_o(addr_o), .ctrl_o(ctrl_o), .err_o(err_o)
  );

  // expected {err, ctrl, addr} from the requirements
  function automatic logic [13:0] ref_map(input logic [7:0] p, input logic w,
                                          input logic [7:0] o, input logic pr);
    logic [7:0] a;
    logic       e;
    if (!w || o[7:4] == 4'hE) a = {p[7:4], o[3:0]};
    else                      a = o;
    e = (p == 8'hE0);
    if (pr && a[0]) begin
      e = 1'b1;
      a[0] = 1'b0;
    end
    return {e, (p[3:0] == 4'h0) && (a[7:4] == 4'hF), p[3:0], a};
  endfunction

  task automatic check(input logic [13:0] exp, input string tag);
    checks++;
    if ({err_o, ctrl_o, addr_o} !== exp) begin
      failures++;
      $display("FAIL %s: got err=%0b ctrl=%0b addr=%h, expected err=%0b ctrl=%0b addr=%h",
               tag, err_o, ctrl_o, addr_o, exp[13], exp[12], exp[11:0]);
    end
  endtask

  // pipelined: compare the previous vector, then drive the next
  task automatic step(input logic [7:0] p, input logic w, input logic [7:0] o,
                      input logic pr, input logic [13:0] exp, input string tag);
    @(negedge clk);
    if (pend) check(pend_exp, pend_tag);
    ptr_i = p; wide_i = w; opnd_i = o; pair_i = pr;
    pend = 1; pend_exp = exp; pend_tag = tag;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) check(pend_exp, pend_tag);
    pend = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R7: reset holds outputs at zero even with a control-area operand applied
    rst = 1'b1; ptr_i = 8'hE0; wide_i = 1'b1; opnd_i = 8'hFF; pair_i = 1'b1;
    repeat (3) @(negedge clk);
    check(14'h0, "R7 reset");
    rst = 1'b0;

    // vector table
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][31:24], VEC[i][23], VEC[i][22:15], VEC[i][14],
           {VEC[i][0], VEC[i][1], VEC[i][13:2]}, VTAG[i]);
    flush();

    // R7: single-cycle latency of the output register
    @(negedge clk);
    ptr_i = 8'h31; wide_i = 1'b1; opnd_i = 8'h9A; pair_i = 1'b0;
    @(negedge clk);
    check(ref_map(8'h31, 1'b1, 8'h9A, 1'b0), "R7 latency");

    // R7: reset mid-run clears outputs
    rst = 1'b1;
    ptr_i = 8'h00; opnd_i = 8'hFC;
    @(negedge clk);
    check(14'h0, "R7 mid reset");
    rst = 1'b0;

    // full sweep: working operands with varied upper nibble (R1, R8)
    for (int p = 0; p < 256; p++)
      for (int o = 0; o < 16; o++) begin
        logic [7:0] op;
        op = {p[3:0] ^ 4'h9, o[3:0]};
        step(p[7:0], 1'b0, op, 1'b0, ref_map(p[7:0], 1'b0, op, 1'b0), "R1 R8 R4 R5");
      end
    // full sweep: 8-bit operands (R2, R3)
    for (int p = 0; p < 256; p++)
      for (int o = 0; o < 256; o++)
        step(p[7:0], 1'b1, o[7:0], 1'b0, ref_map(p[7:0], 1'b1, o[7:0], 1'b0),
             (o[7:4] == 4'hE) ? "R3 R4 R5" : "R2 R4 R5");
    // pair sweep (R6)
    for (int p = 0; p < 256; p++)
      for (int o = 0; o < 16; o++) begin
        logic w;
        w = p[0];
        step(p[7:0], w, {p[7:4], o[3:0]}, 1'b1,
             ref_map(p[7:0], w, {p[7:4], o[3:0]}, 1'b1), "R6");
      end
    flush();

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule